// File: doc/BRIEF.md
# Transmit Loss-of-Signal Monitor

This block supervises one transmit channel for loss of signal. An external amplitude comparator raises a flag in each bit period in which it sees a pulse above its threshold. The threshold is picked by a 2-bit select that the block passes to the comparator unchanged. The block counts consecutive bit periods without a valid pulse. Once the count reaches a programmable quiet period, it declares loss of signal. A single valid pulse clears the declaration on the next clock edge.

The live status drives a sticky interrupt status bit. That bit is set on a rising status edge only, or on either edge, as an edge-select input chooses. It is cleared by a write-one-to-clear strobe and feeds a maskable interrupt output. Each new declaration also gives a one-cycle count-enable to an external error counter. Every clock cycle is one monitored bit period.

Top module: `txlos_monitor`

## Requirements
- R1: With the period select at code c (0 to 3), loss of signal is declared after 32 << c consecutive cycles with pulse_ok_i low. los_o goes to 1 at the clock edge that ends the last of those cycles, and stays 0 before it.
- R2: thresh_sel_o always equals thresh_sel_i.
- R3: A cycle with pulse_ok_i high clears los_o at the following clock edge and restarts the quiet count.
- R4: los_o reads 1 while loss of signal is declared and 0 otherwise, and holds while no valid pulse arrives.
- R5: With edge_any_i = 0, only a 0-to-1 change of los_o sets int_status_o, one edge later. With edge_any_i = 1, a change of los_o in either direction sets it.
- R6: irq_o is 1 exactly when int_status_o is 1 and int_mask_i is 0.
- R7: err_cnt_en_o is high for exactly the one cycle after each 0-to-1 change of los_o.
- R8: int_clr_i high for a cycle clears int_status_o at the next edge. If a qualifying status edge is due at that same edge, int_status_o is set instead.
- R9: srst_i high for a cycle clears the quiet count, los_o and int_status_o at the next edge.
- R10: A change of period_sel_i restarts the quiet count. The cycle in which the change is seen does not count, and a full new period follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one monitored bit period per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous clear of count, status and sticky bit |
| pulse_ok_i | input | 1 | Comparator saw a pulse above threshold this cycle |
| period_sel_i | input | 2 | Quiet-period code, 32 << code cycles |
| thresh_sel_i | input | 2 | Amplitude threshold code |
| thresh_sel_o | output | 2 | Threshold code passed to the comparator |
| edge_any_i | input | 1 | 0: rising edge only sets the sticky bit, 1: any edge |
| int_mask_i | input | 1 | Masks irq_o |
| int_clr_i | input | 1 | Write-one-to-clear strobe for the sticky bit |
| los_o | output | 1 | Live loss-of-signal status |
| int_status_o | output | 1 | Sticky interrupt status |
| irq_o | output | 1 | Interrupt request |
| err_cnt_en_o | output | 1 | One-cycle count enable per declaration |

## Verification
los_o is registered. It changes at the edge that ends the 32 << c-th quiet cycle, or at the edge after a cycle with pulse_ok_i high. err_cnt_en_o is high for the single cycle after that rise. int_status_o follows one edge after a change of los_o, and irq_o and thresh_sel_o follow their inputs within the same cycle. The bench drives inputs after the falling edge and samples at the next falling edge, so each check falls in the cycle in which its result is due. For every period code and both edge modes, the bench samples los_o one cycle before the expected declaration and again at it.

// File: rtl/txlos_pkg.sv
package txlos_pkg;
  localparam int unsigned BASE_LOG2 = 5;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned CNT_W     = BASE_LOG2 + (1 << SEL_W);

  function automatic logic [CNT_W-1:0] quiet_limit(input logic [SEL_W-1:0] sel);
    return CNT_W'(1) << (BASE_LOG2 + int'(sel));
  endfunction
endpackage

// File: rtl/quiet_timer.sv
module quiet_timer
  import txlos_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             pulse_ok_i,
  input  logic [SEL_W-1:0] period_sel_i,
  output logic             los_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
      los_o <= 1'b0;
    end else begin
      sel_q <= period_sel_i;
      if (srst_i) begin
        cnt_q <= '0;
        los_o <= 1'b0;
      end else if (pulse_ok_i) begin
        cnt_q <= '0;
        los_o <= 1'b0;
      end else if (sel_q != period_sel_i) begin
        cnt_q <= '0;  // stale count discarded
      end else if (!los_o) begin
        if (cnt_nxt == quiet_limit(period_sel_i)) begin
          cnt_q <= '0;
          los_o <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/los_irq_ctrl.sv
module los_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic los_i,
  input  logic edge_any_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic int_status_o,
  output logic irq_o,
  output logic rise_o
);
  logic los_prev_q;
  logic fall;
  logic set_ev;

  assign rise_o = los_i & ~los_prev_q;
  assign fall   = ~los_i & los_prev_q;
  assign set_ev = rise_o | (edge_any_i & fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_prev_q   <= 1'b0;
      int_status_o <= 1'b0;
    end else if (srst_i) begin
      los_prev_q   <= 1'b0;
      int_status_o <= 1'b0;
    end else begin
      los_prev_q <= los_i;
      if (set_ev)     int_status_o <= 1'b1;  // set beats clear
      else if (clr_i) int_status_o <= 1'b0;
    end
  end

  assign irq_o = int_status_o & ~mask_i;
endmodule

// File: rtl/txlos_monitor.sv
module txlos_monitor
  import txlos_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             pulse_ok_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic [SEL_W-1:0] thresh_sel_i,
  output logic [SEL_W-1:0] thresh_sel_o,
  input  logic             edge_any_i,
  input  logic             int_mask_i,
  input  logic             int_clr_i,
  output logic             los_o,
  output logic             int_status_o,
  output logic             irq_o,
  output logic             err_cnt_en_o
);
  assign thresh_sel_o = thresh_sel_i;

  quiet_timer i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst_i),
    .pulse_ok_i   (pulse_ok_i),
    .period_sel_i (period_sel_i),
    .los_o        (los_o)
  );

  los_irq_ctrl i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst_i),
    .los_i        (los_o),
    .edge_any_i   (edge_any_i),
    .mask_i       (int_mask_i),
    .clr_i        (int_clr_i),
    .int_status_o (int_status_o),
    .irq_o        (irq_o),
    .rise_o       (err_cnt_en_o)
  );
endmodule

// File: rtl/txlos_monitor_chk.sv
module txlos_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic pulse_ok_i,
  input logic int_mask_i,
  input logic int_clr_i,
  input logic los_o,
  input logic int_status_o,
  input logic irq_o,
  input logic err_cnt_en_o
);
  assert_los_rise_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> !$past(pulse_ok_i));

  assert_pulse_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_ok_i |=> !los_o);

  assert_sticky_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_status_o) |-> ($past(los_o, 1) != $past(los_o, 2)));

  assert_mask_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_mask_i |-> !irq_o);

  assert_cnt_en_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_en_o |-> (los_o && !$past(los_o)));

  assert_sticky_fall_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_status_o) |-> $past(int_clr_i || srst_i));

  assert_srst_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!los_o && !int_status_o));
endmodule

bind txlos_monitor txlos_monitor_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srst_i       (srst_i),
  .pulse_ok_i   (pulse_ok_i),
  .int_mask_i   (int_mask_i),
  .int_clr_i    (int_clr_i),
  .los_o        (los_o),
  .int_status_o (int_status_o),
  .irq_o        (irq_o),
  .err_cnt_en_o (err_cnt_en_o)
);

// File: tb/test_txlos_monitor.sv
`timescale 1ns/1ps
module test_txlos_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic       pulse_ok_i = 1'b0;
  logic [1:0] period_sel_i = 2'd0;
  logic [1:0] thresh_sel_i = 2'd0;
  logic [1:0] thresh_sel_o;
  logic       edge_any_i = 1'b0;
  logic       int_mask_i = 1'b0;
  logic       int_clr_i = 1'b0;
  logic       los_o, int_status_o, irq_o, err_cnt_en_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  txlos_monitor i_txlos_monitor (
    .clk_i, .rst_ni, .srst_i, .pulse_ok_i, .period_sel_i, .thresh_sel_i,
    .thresh_sel_o, .edge_any_i, .int_mask_i, .int_clr_i, .los_o,
    .int_status_o, .irq_o, .err_cnt_en_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge; inputs change and outputs are sampled at falling edges
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic quiet(input int n);
    pulse_ok_i = 1'b0;
    tick(n);
  endtask

  task automatic pulse();
    pulse_ok_i = 1'b1;
    tick();
    pulse_ok_i = 1'b0;
  endtask

  task automatic clear_int();
    int_clr_i = 1'b1;
    tick();
    int_clr_i = 1'b0;
  endtask

  initial begin
    tick(2);
    chk("R4 reset los", los_o, 0);
    chk("R5 reset int_status", int_status_o, 0);
    chk("R7 reset cnt_en", err_cnt_en_o, 0);
    rst_ni = 1'b1;
    tick();

    for (int t = 0; t < 4; t++) begin
      thresh_sel_i = 2'(t);
      #1 chk("R2 threshold pass", thresh_sel_o, t);
    end

    for (int em = 0; em < 2; em++) begin
      for (int c = 0; c < 4; c++) begin
        int lim;
        lim = 32 << c;
        edge_any_i   = em[0];
        int_mask_i   = c[0];
        period_sel_i = 2'(c);
        pulse();
        clear_int();
        quiet(lim - 2);  // clear_int cycle was already quiet
        chk("R1 not yet declared", los_o, 0);
        chk("R7 no early cnt_en", err_cnt_en_o, 0);
        quiet(1);
        chk("R1 declared at limit", los_o, 1);
        chk("R7 cnt_en on rise", err_cnt_en_o, 1);
        chk("R5 sticky not yet", int_status_o, 0);
        quiet(1);
        chk("R7 cnt_en one cycle", err_cnt_en_o, 0);
        chk("R5 sticky on rise", int_status_o, 1);
        chk("R6 irq vs mask", irq_o, c[0] ? 0 : 1);
        quiet(40);
        chk("R4 los held", los_o, 1);
        clear_int();
        chk("R8 w1c clears", int_status_o, 0);
        chk("R6 irq after clear", irq_o, 0);
        pulse();
        chk("R3 pulse clears los", los_o, 0);
        quiet(1);
        chk("R5 fall edge per mode", int_status_o, em);
        chk("R7 no cnt_en on fall", err_cnt_en_o, 0);
      end
    end

    // R8: set wins over a simultaneous clear
    edge_any_i = 1'b0; int_mask_i = 1'b0; period_sel_i = 2'd0;
    pulse();
    clear_int();
    quiet(30);
    chk("R8 before rise", los_o, 0);
    quiet(1);
    chk("R8 rise seen", los_o, 1);
    int_clr_i = 1'b1;
    tick();
    int_clr_i = 1'b0;
    chk("R8 set beats clear", int_status_o, 1);

    // R9: synchronous clear
    srst_i = 1'b1;
    tick();
    srst_i = 1'b0;
    chk("R9 los cleared", los_o, 0);
    chk("R9 sticky cleared", int_status_o, 0);
    quiet(31);
    chk("R9 count restarted", los_o, 0);
    quiet(1);
    chk("R9 full period after clear", los_o, 1);

    // R10: period change restarts the count
    pulse();
    clear_int();
    quiet(19);
    period_sel_i = 2'd1;
    tick();           // change seen, count restarts
    quiet(63);
    chk("R10 no early declare", los_o, 0);
    quiet(1);
    chk("R10 declared after new period", los_o, 1);

    // R3: one pulse within a quiet run restarts the count
    period_sel_i = 2'd0;
    pulse();
    quiet(20);
    pulse();
    quiet(31);
    chk("R3 count restarted by pulse", los_o, 0);
    quiet(1);
    chk("R3 declared after restart", los_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule